// File: doc/BRIEF.md
# Cylinder/Head/Sector Offset Sequencer

This block turns a disk request, given as cylinder, head and sector fields, into the byte offsets a transfer engine needs. The geometry is read from one of two per-drive register pairs (heads and sectors per track), chosen by a drive-select bit. The block captures the request on a start pulse and computes the starting linear sector index with one shared multiply-add unit over two cycles. It then hands out one offset per sector, each a multiple of the sector size. The consumer takes an offset by raising a ready signal while the offset is valid.

The controller is a state machine with six named states. IDLE waits for start. MUL_A forms heads times cylinder plus head. MUL_B multiplies that by sectors per track and adds the zero-based sector. LOAD shifts the index into a byte offset. EMIT presents offsets until the last one is taken. FIN raises done for one cycle and then returns to IDLE. The transitions are IDLE to MUL_A on a good start, MUL_A to MUL_B, MUL_B to LOAD and LOAD to EMIT, each after one cycle. EMIT loops on itself until the last accept and then goes to FIN, and FIN goes back to IDLE. A start that asks for linear block mode, or that gives sector field 0, is refused in IDLE: it raises an address-error pulse and the block stays in IDLE.

Top module: `chs_offset_gen`

## Requirements
- R1: The cylinder used is cyl_hi times 256 plus cyl_lo.
- R2: The first offset equals 512 times ((sector_num - 1) + head_num × spt + heads × spt × cylinder). heads and spt come from heads_d0/spt_d0 when drive_sel is 0 and from heads_d1/spt_d1 when drive_sel is 1.
- R3: For an accepted start, offset_valid first rises three cycles after the start edge, in the cycle that follows the fourth rising edge counted from the one that sampled start. It is high only while busy is high.
- R4: While offset_valid is high and offset_ready is low, offset_valid and offset hold. After each accept (valid and ready at an edge), the next offset is the previous one plus 512.
- R5: A transfer yields exactly sec_count offsets, or 256 offsets when sec_count is 0.
- R6: done is a one-cycle pulse in the cycle after the last offset is accepted. It is never high together with offset_valid, and busy is low in the cycle after it.
- R7: A start with lba_mode at 1, or with sector_num at 0, produces a one-cycle addr_err pulse in the next cycle. It produces no offset and no done, and busy stays low.
- R8: A start pulse while busy is high is ignored: the transfer in progress keeps its offsets and count.
- R9: While rst_n is low, offset_valid, done, addr_err and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, sampled in IDLE |
| lba_mode | input | 1 | Linear block mode requested (refused) |
| drive_sel | input | 1 | Drive whose geometry is used |
| head_num | input | 4 | Head field of the request |
| sector_num | input | 8 | One-based sector field |
| cyl_lo | input | 8 | Cylinder low byte |
| cyl_hi | input | 8 | Cylinder high byte |
| sec_count | input | 8 | Sectors to transfer, 0 meaning 256 |
| heads_d0 | input | HEADS_W | Head count of drive 0 |
| spt_d0 | input | SPT_W | Sectors per track of drive 0 |
| heads_d1 | input | HEADS_W | Head count of drive 1 |
| spt_d1 | input | SPT_W | Sectors per track of drive 1 |
| offset_ready | input | 1 | Consumer takes the current offset |
| offset | output | OFF_W | Byte offset of the current sector |
| offset_valid | output | 1 | offset is valid |
| done | output | 1 | Pulse after the last accept |
| addr_err | output | 1 | Pulse for a refused request |
| busy | output | 1 | A transfer is in progress |

## Verification
The bench uses the default parameters: a 5-bit head count, an 8-bit sectors-per-track value and the 512-byte sector shift, which gives a 39-bit offset. This lets drive 1 be set to 16 heads and 63 sectors per track. With the full 16-bit cylinder 0xFFFF, the highest head and the last sector, the product chain runs at its widest. A 256-sector transfer with random stalls on the ready side checks the zero-count rule and the hold behaviour together.

// File: rtl/chs_pkg.sv
package chs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MUL_A,
        ST_MUL_B,
        ST_LOAD,
        ST_EMIT,
        ST_FIN
    } chs_state_e;
endpackage

// File: rtl/chs_geo_sel.sv
module chs_geo_sel #(
    parameter int HEADS_W = 5,
    parameter int SPT_W   = 8
) (
    input  logic               sel,
    input  logic [HEADS_W-1:0] heads_a,
    input  logic [SPT_W-1:0]   spt_a,
    input  logic [HEADS_W-1:0] heads_b,
    input  logic [SPT_W-1:0]   spt_b,
    output logic [HEADS_W-1:0] heads_o,
    output logic [SPT_W-1:0]   spt_o
);
    // drive 1 geometry when sel is high (R2)
    always_comb begin
        heads_o = sel ? heads_b : heads_a;
        spt_o   = sel ? spt_b   : spt_a;
    end
endmodule

// File: rtl/chs_muladd.sv
module chs_muladd #(
    parameter int AW = 30,
    parameter int BW = 16,
    parameter int YW = 30
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic [AW-1:0] c,
    output logic [YW-1:0] y
);
    logic [YW-1:0] y_q;

    always_ff @(posedge clk) begin
        if (en) begin
            y_q <= YW'(a) * YW'(b) + YW'(c);
        end
    end

    assign y = y_q;
endmodule

// File: rtl/chs_offset_gen.sv
module chs_offset_gen #(
    parameter  int HEADS_W   = 5,
    parameter  int SPT_W     = 8,
    parameter  int SECT_LOG2 = 9,
    localparam int CYL_W     = 16,
    localparam int CNT_W     = 8,
    localparam int REM_W     = CNT_W + 1,
    localparam int IDX_W     = HEADS_W + CYL_W + SPT_W + 1,
    localparam int OFF_W     = IDX_W + SECT_LOG2,
    localparam int MB_W      = (CYL_W > SPT_W) ? CYL_W : SPT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               lba_mode,
    input  logic               drive_sel,
    input  logic [3:0]         head_num,
    input  logic [7:0]         sector_num,
    input  logic [7:0]         cyl_lo,
    input  logic [7:0]         cyl_hi,
    input  logic [7:0]         sec_count,
    input  logic [HEADS_W-1:0] heads_d0,
    input  logic [SPT_W-1:0]   spt_d0,
    input  logic [HEADS_W-1:0] heads_d1,
    input  logic [SPT_W-1:0]   spt_d1,
    input  logic               offset_ready,
    output logic [OFF_W-1:0]   offset,
    output logic               offset_valid,
    output logic               done,
    output logic               addr_err,
    output logic               busy
);
    import chs_pkg::*;

    localparam logic [OFF_W-1:0] STEP    = OFF_W'(1) << SECT_LOG2;
    localparam logic [REM_W-1:0] FULL_CT = REM_W'(1) << CNT_W;

    chs_state_e st_q, st_d;

    logic [3:0]       head_q;
    logic [7:0]       sec_q;
    logic [CYL_W-1:0] cyl_q;
    logic             drv_q;
    logic [REM_W-1:0] rem_q;
    logic [OFF_W-1:0] off_q;
    logic             err_q;

    logic             bad_req;
    logic             go;
    logic             accept;
    logic             last;

    logic [HEADS_W-1:0] heads_g;
    logic [SPT_W-1:0]   spt_g;
    logic               mac_en;
    logic [IDX_W-1:0]   mac_a;
    logic [MB_W-1:0]    mac_b;
    logic [IDX_W-1:0]   mac_c;
    logic [IDX_W-1:0]   mac_y;

    assign bad_req = lba_mode || (sector_num == 8'd0);
    assign go      = (st_q == ST_IDLE) && start && !bad_req;
    assign accept  = (st_q == ST_EMIT) && offset_ready;
    assign last    = (rem_q == REM_W'(1));

    chs_geo_sel #(.HEADS_W(HEADS_W), .SPT_W(SPT_W)) u_geo (
        .sel     (drv_q),
        .heads_a (heads_d0),
        .spt_a   (spt_d0),
        .heads_b (heads_d1),
        .spt_b   (spt_d1),
        .heads_o (heads_g),
        .spt_o   (spt_g)
    );

    // MUL_A: heads*cyl + head ; MUL_B: (..)*spt + (sector-1)
    always_comb begin
        mac_en = (st_q == ST_MUL_A) || (st_q == ST_MUL_B);
        if (st_q == ST_MUL_B) begin
            mac_a = mac_y;
            mac_b = MB_W'(spt_g);
            mac_c = IDX_W'(sec_q - 8'd1);
        end else begin
            mac_a = IDX_W'(heads_g);
            mac_b = MB_W'(cyl_q);
            mac_c = IDX_W'(head_q);
        end
    end

    chs_muladd #(.AW(IDX_W), .BW(MB_W), .YW(IDX_W)) u_mac (
        .clk (clk),
        .en  (mac_en),
        .a   (mac_a),
        .b   (mac_b),
        .c   (mac_c),
        .y   (mac_y)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (go) st_d = ST_MUL_A;
            ST_MUL_A: st_d = ST_MUL_B;
            ST_MUL_B: st_d = ST_LOAD;
            ST_LOAD:  st_d = ST_EMIT;
            ST_EMIT:  if (accept && last) st_d = ST_FIN;
            ST_FIN:   st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            sec_q  <= '0;
            cyl_q  <= '0;
            drv_q  <= 1'b0;
            rem_q  <= '0;
            off_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= (st_q == ST_IDLE) && start && bad_req;
            if (go) begin
                head_q <= head_num;
                sec_q  <= sector_num;
                cyl_q  <= {cyl_hi, cyl_lo};
                drv_q  <= drive_sel;
                rem_q  <= (sec_count == 8'd0) ? FULL_CT : REM_W'(sec_count);
            end
            if (st_q == ST_LOAD) begin
                off_q <= OFF_W'(mac_y) << SECT_LOG2;
            end else if (accept) begin
                off_q <= off_q + STEP;
                rem_q <= rem_q - REM_W'(1);
            end
        end
    end

    always_comb begin
        offset       = off_q;
        offset_valid = (st_q == ST_EMIT);
        done         = (st_q == ST_FIN);
        busy         = (st_q != ST_IDLE);
        addr_err     = err_q;
    end
endmodule

// File: rtl/chs_offset_gen_chk.sv
module chs_offset_gen_chk #(
    parameter int OFF_W     = 39,
    parameter int SECT_LOG2 = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             offset_ready,
    input logic [OFF_W-1:0] offset,
    input logic             offset_valid,
    input logic             done,
    input logic             addr_err,
    input logic             busy
);
    localparam logic [OFF_W-1:0] STEP = OFF_W'(1) << SECT_LOG2;

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid && !offset_ready |=> offset_valid && $stable(offset));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid && offset_ready |=> done || (offset_valid && offset == $past(offset) + STEP));

    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && offset_valid));

    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> !busy && !offset_valid && !done);

    a_r3_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid |-> busy);
endmodule

bind chs_offset_gen chs_offset_gen_chk #(.OFF_W(OFF_W), .SECT_LOG2(SECT_LOG2)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .offset_ready (offset_ready),
    .offset       (offset),
    .offset_valid (offset_valid),
    .done         (done),
    .addr_err     (addr_err),
    .busy         (busy)
);

// File: tb/tb_chs_offset_gen.sv
module tb_chs_offset_gen;
    localparam int HEADS_W = 5;
    localparam int SPT_W   = 8;
    localparam int OFF_W   = HEADS_W + 16 + SPT_W + 1 + 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, lba_mode = 1'b0, drive_sel = 1'b0;
    logic [3:0] head_num = '0;
    logic [7:0] sector_num = '0, cyl_lo = '0, cyl_hi = '0, sec_count = '0;
    logic [HEADS_W-1:0] heads_d0 = 5'd4, heads_d1 = 5'd16;
    logic [SPT_W-1:0]   spt_d0 = 8'd17, spt_d1 = 8'd63;
    logic offset_ready = 1'b0;
    logic [OFF_W-1:0] offset;
    logic offset_valid, done, addr_err, busy;

    int checks = 0, errors = 0;
    bit stall_en = 1'b0;
    bit finished = 1'b0;
    int dut_acc = 0, dut_err = 0;

    always #5 clk = ~clk;

    chs_offset_gen #(.HEADS_W(HEADS_W), .SPT_W(SPT_W), .SECT_LOG2(9)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lba_mode(lba_mode),
        .drive_sel(drive_sel), .head_num(head_num), .sector_num(sector_num),
        .cyl_lo(cyl_lo), .cyl_hi(cyl_hi), .sec_count(sec_count),
        .heads_d0(heads_d0), .spt_d0(spt_d0), .heads_d1(heads_d1), .spt_d1(spt_d1),
        .offset_ready(offset_ready), .offset(offset), .offset_valid(offset_valid),
        .done(done), .addr_err(addr_err), .busy(busy)
    );

    // behavioural reference: 0 idle, 1 computing, 2 emitting, 3 finishing
    int m_phase = 0;
    int m_wait = 0;
    bit m_err = 1'b0;
    longint q[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0;
            m_err = 1'b0;
            q.delete();
        end else begin
            m_err = 1'b0;
            case (m_phase)
                0: if (start) begin
                    if (lba_mode || sector_num == 0) begin
                        m_err = 1'b1;                       // R7
                    end else begin
                        longint cyl, hd, sp, idx, n;
                        cyl = longint'(cyl_hi) * 256 + longint'(cyl_lo); // R1
                        hd  = drive_sel ? longint'(heads_d1) : longint'(heads_d0);
                        sp  = drive_sel ? longint'(spt_d1) : longint'(spt_d0);
                        idx = (longint'(sector_num) - 1) + longint'(head_num) * sp + hd * sp * cyl;
                        n   = (sec_count == 0) ? 256 : longint'(sec_count); // R5
                        for (longint k = 0; k < n; k++) q.push_back((idx + k) * 512);
                        m_phase = 1;
                        m_wait = 3;
                    end
                end
                1: begin
                    m_wait--;
                    if (m_wait == 0) m_phase = 2;
                end
                2: if (offset_ready) begin
                    void'(q.pop_front());
                    if (q.size() == 0) m_phase = 3;
                end
                default: m_phase = 0;
            endcase
        end
        if (rst_n && offset_valid && offset_ready) dut_acc++;
        if (rst_n && addr_err) dut_err++;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3 offset_valid", longint'(offset_valid), longint'(m_phase == 2));
            if (m_phase == 2 && q.size() > 0)
                chk("R1/R2/R4 offset", longint'(offset), q[0]);
            chk("R6 done", longint'(done), longint'(m_phase == 3));
            chk("R7 addr_err", longint'(addr_err), longint'(m_err));
            chk("R8 busy", longint'(busy), longint'(m_phase != 0));
        end
    end

    always @(negedge clk) begin
        offset_ready <= stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic issue(input bit drv, input bit lba, input logic [3:0] hd,
                         input logic [7:0] sec, input logic [7:0] clo,
                         input logic [7:0] chi, input logic [7:0] cnt);
        @(negedge clk);
        drive_sel = drv; lba_mode = lba; head_num = hd; sector_num = sec;
        cyl_lo = clo; cyl_hi = chi; sec_count = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_phase != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R9: outputs quiet in reset
        chk("R9 reset valid", longint'(offset_valid), 0);
        chk("R9 reset done", longint'(done), 0);
        chk("R9 reset addr_err", longint'(addr_err), 0);
        chk("R9 reset busy", longint'(busy), 0);
        rst_n = 1'b1;

        // first sector of the disk: offset 0
        issue(1'b0, 1'b0, 4'd0, 8'd1, 8'd0, 8'd0, 8'd1);
        wait_idle();

        // drive 0, mid geometry, several sectors (R2, R4)
        issue(1'b0, 1'b0, 4'd3, 8'd5, 8'h34, 8'h02, 8'd4);
        wait_idle();

        // drive 1 at its widest point with stalls (R1, R2, R4)
        stall_en = 1'b1;
        issue(1'b1, 1'b0, 4'd15, 8'd63, 8'hFF, 8'hFF, 8'd3);
        wait_idle();

        // R5: count 0 means 256 sectors
        base = dut_acc;
        issue(1'b1, 1'b0, 4'd2, 8'd7, 8'd9, 8'd1, 8'd0);
        wait_idle();
        chk("R5 zero count yields 256", longint'(dut_acc - base), 256);

        // R5: count 5
        base = dut_acc;
        issue(1'b0, 1'b0, 4'd1, 8'd17, 8'd200, 8'd0, 8'd5);
        wait_idle();
        chk("R5 count 5", longint'(dut_acc - base), 5);

        // R7: sector 0 and linear-block mode refused
        base = dut_acc;
        issue(1'b0, 1'b0, 4'd0, 8'd0, 8'd1, 8'd0, 8'd2);
        wait_idle();
        issue(1'b1, 1'b1, 4'd1, 8'd3, 8'd1, 8'd0, 8'd2);
        wait_idle();
        chk("R7 no offsets on refusal", longint'(dut_acc - base), 0);
        chk("R7 error pulses", longint'(dut_err), 2);

        // R8: start while busy is ignored
        base = dut_acc;
        issue(1'b0, 1'b0, 4'd2, 8'd4, 8'd10, 8'd0, 8'd6);
        @(negedge clk);
        sector_num = 8'd9; sec_count = 8'd2; drive_sel = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        chk("R8 busy start ignored count", longint'(dut_acc - base), 6);

        stall_en = 1'b0;
        repeat (4) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, actual=hung expected=idle");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule